// File: doc/BRIEF.md
# Peripheral Port Register File

This block is the register side of one 8-bit parallel port on a 6502-style bus. It holds a direction register, an output register and a 6-bit control register. The CPU reaches them through a two-bit address. One control bit chooses whether the port's data address goes to the direction register or to the output register. The two address lines reach the register-select inputs crossed by default, which places the port data at CPU offset 1 and its control at offset 3. Offsets 0 and 2 belong to a companion port that this block does not hold.

Bus writes are captured while PH2 is high and take effect when PH2 falls. Reads are combinational while chip select is active and R/W is high. Pins are resolved inside the block. A direction bit of 1 drives the output-register bit. A direction bit of 0 leaves the pin undriven, so it shows an external driver's value or otherwise the pull-up level of 1.

The bus is a plain strobed interface with no valid/ready handshake and no back-pressure. Every access completes in the PH2 cycle that carries it.

Top module: `pp_port`

## Requirements
- R1: After reset the direction and output registers are 0, so `pin_oe` is 8'h00, `pin_out` is 8'hFF and a read of the port data address returns the direction register, 8'h00. With the default option, a read of the control address returns 8'h00.
- R2: A register changes only at a falling edge of PH2, and only if chip select was 1 and R/W was 0 in the last system-clock cycle with PH2 high. While PH2 stays high nothing is written. A cycle with chip select 0 or R/W 1 changes no register.
- R3: With the default crossed select (address bit 1 drives RS0, address bit 0 drives RS1), port data is at offset 1 and port control is at offset 3. Offsets 0 and 2 read 8'h00, and writes to them change nothing.
- R4: When control bit 2 is 1, the port data address reads and writes the output register. When it is 0, that address reads and writes the direction register.
- R5: `pin_oe` equals the direction register. `pin_out` carries the output-register bit where the direction bit is 1, and 1 where it is 0.
- R6: A port data read with control bit 2 at 1 returns the output-register bit for each output pin. For each input pin it returns the external value when `pin_ext_en` is 1, and 1 otherwise. External drive on an output pin is ignored.
- R7: A control read returns bits 5..0 as last written, with bits 7..6 reading 0.
- R8: A port data read with control bit 2 at 0 returns the direction register as written.
- R9: With the inversion option set, control bit 2 resets to 1, so the data address reaches the output register first. With crossing disabled, port data moves to offset 2 and control stays at offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| ph2 | input | 1 | Bus phase-2 clock level |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | CPU address bits 1..0 |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Read data, 0 when not reading |
| pin_ext_en | input | 8 | Per-bit: an external device drives the pin |
| pin_ext_val | input | 8 | Value an external device drives |
| pin_out | output | 8 | Pin drive value (1 on undriven pins) |
| pin_oe | output | 8 | Per-bit output enable |

## Verification
Port reads are tried in three patterns that tell the pin sources apart:
- Inputs left floating, which must read the pull-up level.
- Inputs driven externally to values that differ from the output register.
- External drive applied onto output pins, which must be ignored.

Writes are issued through both settings of control bit 2. This separates a write that lands in the output register from one that lands in the direction register. It also shows that switching the bit alone disturbs neither register.

Accesses to offsets 0 and 2 are checked for ignored writes and zero reads, which proves the crossed address lines. A second instance with crossing disabled and the inverted reset option shows both variants.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    PP_NONE = 2'd0,
    PP_DATA = 2'd1,
    PP_CTRL = 2'd2
  } pp_sel_e;
endpackage

// File: rtl/pp_rs_decode.sv
module pp_rs_decode #(
  parameter bit CROSSED   = 1'b1,
  parameter bit PORT_SIDE = 1'b1
) (
  input  logic [1:0]      cpu_a,
  output pp_pkg::pp_sel_e sel
);
  // rs[1] picks the side, rs[0] picks control vs data
  logic [1:0] rs;

  generate
    if (CROSSED) begin : g_crossed
      assign rs = {cpu_a[0], cpu_a[1]};
    end else begin : g_straight
      assign rs = cpu_a;
    end
  endgenerate

  always_comb begin
    if (rs[1] != PORT_SIDE) sel = pp_pkg::PP_NONE;
    else if (rs[0])         sel = pp_pkg::PP_CTRL;
    else                    sel = pp_pkg::PP_DATA;
  end
endmodule

// File: rtl/pp_bus_capture.sv
module pp_bus_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph2,
  input  logic          cs,
  input  logic          rw,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_stb,
  output logic [1:0]    wr_addr,
  output logic [DW-1:0] wr_data
);
  logic ph2_q;
  logic cap_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph2_q   <= 1'b0;
      cap_we  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      ph2_q <= ph2;
      if (ph2) begin
        cap_we  <= cs & ~rw;
        wr_addr <= addr;
        wr_data <= wdata;
      end
    end
  end

  // commit on the first low sample after a high one
  assign wr_stb = ph2_q & ~ph2 & cap_we;
endmodule

// File: rtl/pp_regs.sv
module pp_regs #(
  parameter int DW          = 8,
  parameter int CTRL_BITS   = 6,
  parameter int SEL_BIT     = 2,
  parameter bit SEL_RST_INV = 1'b0,
  parameter bit CROSSED     = 1'b1,
  parameter bit PORT_SIDE   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [1:0]           wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        ddr,
  output logic [DW-1:0]        orb,
  output logic [CTRL_BITS-1:0] ctrl
);
  localparam logic [CTRL_BITS-1:0] CTRL_RST =
    SEL_RST_INV ? (CTRL_BITS'(1) << SEL_BIT) : '0;

  pp_pkg::pp_sel_e wsel;

  pp_rs_decode #(.CROSSED(CROSSED), .PORT_SIDE(PORT_SIDE)) u_wdec (
    .cpu_a (wr_addr),
    .sel   (wsel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr  <= '0;
      orb  <= '0;
      ctrl <= CTRL_RST;
    end else if (wr_stb) begin
      case (wsel)
        pp_pkg::PP_CTRL: ctrl <= wr_data[CTRL_BITS-1:0];
        pp_pkg::PP_DATA: begin
          if (ctrl[SEL_BIT]) orb <= wr_data;
          else               ddr <= wr_data;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pp_pins.sv
module pp_pins #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ddr,
  input  logic [DW-1:0] orb,
  input  logic [DW-1:0] ext_en,
  input  logic [DW-1:0] ext_val,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] pin_lvl
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      pin_oe[i]  = ddr[i];
      pin_out[i] = ddr[i] ? orb[i] : 1'b1;
      if (ddr[i])         pin_lvl[i] = orb[i];
      else if (ext_en[i]) pin_lvl[i] = ext_val[i];
      else                pin_lvl[i] = 1'b1;
    end
  end
endmodule

// File: rtl/pp_port.sv
module pp_port #(
  parameter int DW          = 8,
  parameter int CTRL_BITS   = 6,
  parameter int SEL_BIT     = 2,
  parameter bit SEL_RST_INV = 1'b0,
  parameter bit CROSSED     = 1'b1,
  parameter bit PORT_SIDE   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph2,
  input  logic          cs,
  input  logic          rw,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_ext_en,
  input  logic [DW-1:0] pin_ext_val,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe
);
  localparam int PAD = DW - CTRL_BITS;

  logic                 wr_stb;
  logic [1:0]           wr_addr;
  logic [DW-1:0]        wr_data;
  logic [DW-1:0]        ddr;
  logic [DW-1:0]        orb;
  logic [CTRL_BITS-1:0] ctrl;
  logic [DW-1:0]        pin_lvl;
  pp_pkg::pp_sel_e      rsel;

  pp_bus_capture #(.DW(DW)) u_cap (
    .clk, .rst_n, .ph2, .cs, .rw, .addr, .wdata,
    .wr_stb, .wr_addr, .wr_data
  );

  pp_regs #(
    .DW(DW), .CTRL_BITS(CTRL_BITS), .SEL_BIT(SEL_BIT),
    .SEL_RST_INV(SEL_RST_INV), .CROSSED(CROSSED), .PORT_SIDE(PORT_SIDE)
  ) u_regs (
    .clk, .rst_n, .wr_stb, .wr_addr, .wr_data, .ddr, .orb, .ctrl
  );

  pp_pins #(.DW(DW)) u_pins (
    .ddr, .orb, .ext_en(pin_ext_en), .ext_val(pin_ext_val),
    .pin_out, .pin_oe, .pin_lvl
  );

  pp_rs_decode #(.CROSSED(CROSSED), .PORT_SIDE(PORT_SIDE)) u_rdec (
    .cpu_a (addr),
    .sel   (rsel)
  );

  always_comb begin
    rdata = '0;
    if (cs && rw) begin
      case (rsel)
        pp_pkg::PP_CTRL: rdata = {{PAD{1'b0}}, ctrl};
        pp_pkg::PP_DATA: rdata = ctrl[SEL_BIT] ? pin_lvl : ddr;
        default:         rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pp_port_chk.sv
module pp_port_chk #(
  parameter int DW        = 8,
  parameter bit CROSSED   = 1'b1,
  parameter bit PORT_SIDE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph2,
  input logic          cs,
  input logic          rw,
  input logic [1:0]    addr,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pin_out,
  input logic [DW-1:0] pin_oe
);
  localparam logic [1:0] CTRL_OFF  = CROSSED ? {1'b1, PORT_SIDE} : {PORT_SIDE, 1'b1};
  localparam logic [1:0] OTHER_D   = CROSSED ? {1'b0, !PORT_SIDE} : {!PORT_SIDE, 1'b0};
  localparam logic [1:0] OTHER_C   = CROSSED ? {1'b1, !PORT_SIDE} : {!PORT_SIDE, 1'b1};

  // R1: the cycle after reset shows no enabled output
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '1));

  // R2: with no PH2 fall, pins hold
  a_r2_no_fall_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(ph2) && !ph2) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R2: a read cycle ending writes nothing
  a_r2_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph2) && !ph2 && $past(rw)) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R5: undriven pins sit at the pull-up level
  a_r5_undriven_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe) == '1));

  // R7: upper control bits read zero
  a_r7_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw && addr == CTRL_OFF) |-> (rdata[DW-1:DW-2] == 2'b00));

  // R3: the companion port's offsets read zero
  a_r3_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw && (addr == OTHER_D || addr == OTHER_C)) |-> (rdata == '0));
endmodule

bind pp_port pp_port_chk #(
  .DW(DW), .CROSSED(CROSSED), .PORT_SIDE(PORT_SIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ph2(ph2), .cs(cs), .rw(rw), .addr(addr),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_pp_port.sv
module tb_pp_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph2 = 1'b0, cs = 1'b0, cs2 = 1'b0, rw = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, ext_en = 8'h00, ext_val = 8'h00;
  logic [7:0] rdata, pin_out, pin_oe, rdata2, pin_out2, pin_oe2;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pp_port dut (
    .clk, .rst_n, .ph2, .cs, .rw, .addr, .wdata, .rdata,
    .pin_ext_en(ext_en), .pin_ext_val(ext_val), .pin_out, .pin_oe
  );

  pp_port #(.CROSSED(1'b0), .SEL_RST_INV(1'b1)) dut2 (
    .clk, .rst_n, .ph2, .cs(cs2), .rw, .addr, .wdata, .rdata(rdata2),
    .pin_ext_en(ext_en), .pin_ext_val(ext_val), .pin_out(pin_out2), .pin_oe(pin_oe2)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] en;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd3, 8'h38, 8'h00, 8'h00, 4'd4}, // R4 select direction
    '{1'b1, 2'd1, 8'h0F, 8'h00, 8'h00, 4'd8},
    '{1'b0, 2'd1, 8'h0F, 8'h00, 8'h00, 4'd8}, // R8 direction readback
    '{1'b1, 2'd3, 8'h3C, 8'h00, 8'h00, 4'd4},
    '{1'b1, 2'd1, 8'hA5, 8'h00, 8'h00, 4'd4},
    '{1'b0, 2'd1, 8'hF5, 8'h00, 8'h00, 4'd6}, // R6 floating inputs read 1
    '{1'b0, 2'd1, 8'h35, 8'hF0, 8'h30, 4'd6}, // R6 driven inputs
    '{1'b0, 2'd1, 8'hF5, 8'h0F, 8'h00, 4'd6}, // R6 drive on outputs ignored
    '{1'b0, 2'd3, 8'h3C, 8'h00, 8'h00, 4'd7},
    '{1'b1, 2'd3, 8'hFF, 8'h00, 8'h00, 4'd7},
    '{1'b0, 2'd3, 8'h3F, 8'h00, 8'h00, 4'd7}, // R7 top bits zero
    '{1'b1, 2'd0, 8'h77, 8'h00, 8'h00, 4'd3},
    '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 4'd3},
    '{1'b0, 2'd3, 8'h3F, 8'h00, 8'h00, 4'd3}, // R3 offset 2 is not our control
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd3},
    '{1'b0, 2'd2, 8'h00, 8'h00, 8'h00, 4'd3},
    '{1'b0, 2'd1, 8'hF5, 8'h00, 8'h00, 4'd3}, // R3 offset 0 write ignored
    '{1'b1, 2'd3, 8'h38, 8'h00, 8'h00, 4'd4},
    '{1'b0, 2'd1, 8'h0F, 8'h00, 8'h00, 4'd4},
    '{1'b1, 2'd1, 8'hFF, 8'h00, 8'h00, 4'd4},
    '{1'b1, 2'd3, 8'h3C, 8'h00, 8'h00, 4'd4},
    '{1'b0, 2'd1, 8'hA5, 8'h00, 8'h00, 4'd4}  // R4 output register kept
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit second, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = !second; cs2 = second; rw = 1'b0; addr = a; wdata = d; ph2 = 1'b1;
    @(negedge clk); ph2 = 1'b0;
    @(negedge clk); cs = 1'b0; cs2 = 1'b0; rw = 1'b1;
  endtask

  task automatic bus_rd(input bit second, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = !second; cs2 = second; rw = 1'b1; addr = a; ph2 = 1'b1;
    #5 d = second ? rdata2 : rdata;
    @(negedge clk); ph2 = 1'b0;
    @(negedge clk); cs = 1'b0; cs2 = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'hFF);
    bus_rd(0, 2'd3, r); check("R1 ctrl", r, 8'h00);
    bus_rd(0, 2'd1, r); check("R1 ddr", r, 8'h00);
    // R9 inverted select, straight wiring
    bus_rd(1, 2'd3, r); check("R9 ctrl", r, 8'h04);
    bus_wr(1, 2'd2, 8'hFF);
    @(negedge clk);
    check("R9 orb first", pin_oe2, 8'h00);
    bus_rd(1, 2'd2, r); check("R9 read", r, 8'hFF);
    bus_wr(1, 2'd3, 8'h00);
    bus_wr(1, 2'd2, 8'h0F);
    @(negedge clk);
    check("R9 ddr", pin_oe2, 8'h0F);
    check("R9 out", pin_out2, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      ext_en = VECS[i].en; ext_val = VECS[i].val;
      if (VECS[i].wr) bus_wr(0, VECS[i].a, VECS[i].d);
      else begin
        bus_rd(0, VECS[i].a, r);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].d);
      end
    end
    ext_en = 8'h00;

    // R5 pin resolution
    @(negedge clk);
    check("R5 oe all", pin_oe, 8'hFF);
    check("R5 out all", pin_out, 8'hA5);
    bus_wr(0, 2'd3, 8'h38);
    bus_wr(0, 2'd1, 8'h0F);
    @(negedge clk);
    check("R5 oe half", pin_oe, 8'h0F);
    check("R5 out half", pin_out, 8'hF5);

    // R2 chip select low: no write
    @(negedge clk);
    cs = 1'b0; rw = 1'b0; addr = 2'd1; wdata = 8'h00; ph2 = 1'b1;
    @(negedge clk); ph2 = 1'b0;
    @(negedge clk); rw = 1'b1;
    @(negedge clk);
    check("R2 cs low", pin_oe, 8'h0F);
    // R2 read cycle: no write
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; wdata = 8'h00; ph2 = 1'b1;
    @(negedge clk); ph2 = 1'b0;
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    check("R2 read", pin_oe, 8'h0F);
    // R2 long PH2 high: nothing until the fall
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; wdata = 8'hFF; ph2 = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 held high", pin_oe, 8'h0F);
    ph2 = 1'b0;
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
    check("R2 after fall", pin_oe, 8'hFF);

    // R1 reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 again oe", pin_oe, 8'h00);
    bus_rd(0, 2'd3, r); check("R1 again ctrl", r, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule